// File: doc/BRIEF.md
# Conditional branch target unit

This block resolves a branch once its operands are known. Each operation is issued for one cycle with a condition setting for the count register, a condition setting for one bit of the condition word, a choice of target source and a link-save flag. One cycle later the block reports whether the branch is taken and which address to fetch next. It also reports the link register write to make and, when asked, the count register value after a decrement by one.

The count and link registers live outside the block. Their current values come in as operands and any new values go out as write requests. A decrement can come with a branch, or it can be issued on its own with no branch at all. When the decrement comes with a branch, the zero test on the counter looks at the decremented value. Targets taken from the count or link register have their low alignment bits cleared.

Top module: `branch_resolve`

## Requirements
- R1: After reset, and until the first operation is issued, `redir_o`, `taken_o`, `lr_we_o` and `ctr_we_o` are low.
- R2: The results of an operation sampled with `go_i` high appear on the outputs in the next cycle. `redir_o` is high for exactly that cycle.
- R3: The counter condition `ctr_test_i` uses these codes: 1 means taken only if the counter is nonzero, 2 means taken only if the counter is zero, and 0 or 3 means the counter is not tested.
- R4: The bit condition `bit_test_i` tests whether `cr_i & mask_i` is nonzero, with `mask_i` one-hot. Code 1 needs the bit set, code 2 needs it clear, and 0 or 3 means no bit test. The branch is taken only when both the counter condition and the bit condition hold, so both fields at 0 gives an unconditional branch.
- R5: When taken, the next address comes from `tgt_sel_i`. Code 0 selects `imm_i`, code 1 selects `ctr_i` with bits [1:0] cleared, code 2 selects `lr_i` with bits [1:0] cleared, and code 3 selects `imm_i`.
- R6: When not taken, `next_pc_o` equals the `seq_i` of that operation.
- R7: With `link_i` high, `lr_we_o` is raised only if the branch is taken, and `lr_wdata_o` equals `seq_i`. With `link_i` low, `lr_we_o` stays low.
- R8: A link-register-target branch that also saves the link uses the incoming `lr_i` as its target, while `seq_i` is reported as the new link value.
- R9: With `dec_i` high, `ctr_we_o` rises in the next cycle and `ctr_wdata_o` is `ctr_i - 1`, wrapping from 0 to all ones.
- R10: When `dec_i` and `go_i` are both high, the counter condition tests `ctr_i - 1`. A counter-register target still uses the undecremented `ctr_i`.
- R11: A decrement issued with `go_i` low causes no redirect and no link write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_i | input | 1 | Branch operation valid this cycle |
| ctr_test_i | input | 2 | Counter condition code |
| bit_test_i | input | 2 | Condition-bit test code |
| tgt_sel_i | input | 2 | Target source code |
| link_i | input | 1 | Save sequential address to link register when taken |
| dec_i | input | 1 | Decrement count register |
| cr_i | input | CW (32) | Condition word |
| mask_i | input | CW (32) | One-hot bit select |
| ctr_i | input | AW (32) | Current count register |
| lr_i | input | AW (32) | Current link register |
| imm_i | input | AW (32) | Immediate target |
| seq_i | input | AW (32) | Sequential next address |
| redir_o | output | 1 | Branch result valid |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | AW (32) | Next fetch address |
| lr_we_o | output | 1 | Link register write request |
| lr_wdata_o | output | AW (32) | New link value |
| ctr_we_o | output | 1 | Count register write request |
| ctr_wdata_o | output | AW (32) | Decremented count value |

## Verification
The checker assumes that `mask_i` has exactly one bit set whenever a bit test is requested, and it flags any other mask as an input fault. It also assumes that operand values are valid in the cycle `go_i` or `dec_i` is high, because the one-cycle properties compare outputs against the past values of those operands. The directed tests always use single-bit masks with bit tests. They set every operand in the issue cycle, and they place the counter at 0, 1 and other values so that the zero test is exercised on both sides of a decrement.

// File: rtl/br_pkg.sv
package br_pkg;
   typedef enum logic [1:0] {CT_NONE = 2'd0, CT_NONZERO = 2'd1, CT_ZERO = 2'd2, CT_RSVD = 2'd3} ctr_test_e;
   typedef enum logic [1:0] {BT_NONE = 2'd0, BT_SET = 2'd1, BT_CLEAR = 2'd2, BT_RSVD = 2'd3} bit_test_e;
   typedef enum logic [1:0] {TG_IMM = 2'd0, TG_CTR = 2'd1, TG_LINK = 2'd2, TG_RSVD = 2'd3} tgt_e;
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
   import br_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 32
)(
   input  ctr_test_e         ctr_test,
   input  bit_test_e         bit_test,
   input  logic [AW-1:0]     ctr_val,
   input  logic [CW-1:0]     cr,
   input  logic [CW-1:0]     mask,
   output logic              pass
);
   logic ctr_zero, bit_hit, ctr_ok, bit_ok;

   assign ctr_zero = ~|ctr_val;
   assign bit_hit  = |(cr & mask);

   always_comb begin
      unique case (ctr_test)
         CT_NONZERO: ctr_ok = ~ctr_zero;
         CT_ZERO:    ctr_ok = ctr_zero;
         default:    ctr_ok = 1'b1;
      endcase
      unique case (bit_test)
         BT_SET:     bit_ok = bit_hit;
         BT_CLEAR:   bit_ok = ~bit_hit;
         default:    bit_ok = 1'b1;
      endcase
   end

   assign pass = ctr_ok & bit_ok;
endmodule

// File: rtl/br_target_sel.sv
module br_target_sel
   import br_pkg::*;
#(
   parameter int AW    = 32,
   parameter int ALIGN = 2
)(
   input  tgt_e           sel,
   input  logic [AW-1:0]  imm,
   input  logic [AW-1:0]  ctr,
   input  logic [AW-1:0]  lr,
   output logic [AW-1:0]  tgt
);
   logic [AW-1:0] ctr_al, lr_al;

   generate
      if (ALIGN > 0) begin : g_align
         assign ctr_al = {ctr[AW-1:ALIGN], {ALIGN{1'b0}}};
         assign lr_al  = {lr[AW-1:ALIGN],  {ALIGN{1'b0}}};
      end else begin : g_noalign
         assign ctr_al = ctr;
         assign lr_al  = lr;
      end
   endgenerate

   always_comb begin
      unique case (sel)
         TG_CTR:  tgt = ctr_al;
         TG_LINK: tgt = lr_al;
         default: tgt = imm;
      endcase
   end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
   import br_pkg::*;
#(
   parameter int AW    = 32,
   parameter int CW    = 32,
   parameter int ALIGN = 2
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go_i,
   input  logic [1:0]     ctr_test_i,
   input  logic [1:0]     bit_test_i,
   input  logic [1:0]     tgt_sel_i,
   input  logic           link_i,
   input  logic           dec_i,
   input  logic [CW-1:0]  cr_i,
   input  logic [CW-1:0]  mask_i,
   input  logic [AW-1:0]  ctr_i,
   input  logic [AW-1:0]  lr_i,
   input  logic [AW-1:0]  imm_i,
   input  logic [AW-1:0]  seq_i,
   output logic           redir_o,
   output logic           taken_o,
   output logic [AW-1:0]  next_pc_o,
   output logic           lr_we_o,
   output logic [AW-1:0]  lr_wdata_o,
   output logic           ctr_we_o,
   output logic [AW-1:0]  ctr_wdata_o
);
   localparam logic [AW-1:0] ONE = AW'(1);

   generate
      if (AW <= ALIGN) begin : g_bad_aw
         $error("branch_resolve: AW must exceed ALIGN");
      end
      if (CW < 1) begin : g_bad_cw
         $error("branch_resolve: CW must be at least 1");
      end
   endgenerate

   logic [AW-1:0] ctr_dec, ctr_eff, tgt;
   logic          pass, taken_d;

   assign ctr_dec = ctr_i - ONE;
   assign ctr_eff = dec_i ? ctr_dec : ctr_i;

   br_cond_eval #(.AW(AW), .CW(CW)) u_cond (
      .ctr_test (ctr_test_e'(ctr_test_i)),
      .bit_test (bit_test_e'(bit_test_i)),
      .ctr_val  (ctr_eff),
      .cr       (cr_i),
      .mask     (mask_i),
      .pass     (pass)
   );

   br_target_sel #(.AW(AW), .ALIGN(ALIGN)) u_tgt (
      .sel (tgt_e'(tgt_sel_i)),
      .imm (imm_i),
      .ctr (ctr_i),
      .lr  (lr_i),
      .tgt (tgt)
   );

   assign taken_d = go_i & pass;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         redir_o     <= 1'b0;
         taken_o     <= 1'b0;
         next_pc_o   <= '0;
         lr_we_o     <= 1'b0;
         lr_wdata_o  <= '0;
         ctr_we_o    <= 1'b0;
         ctr_wdata_o <= '0;
      end else begin
         redir_o     <= go_i;
         taken_o     <= taken_d;
         next_pc_o   <= taken_d ? tgt : seq_i;
         lr_we_o     <= taken_d & link_i;
         lr_wdata_o  <= seq_i;
         ctr_we_o    <= dec_i;
         ctr_wdata_o <= ctr_dec;
      end
   end
endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk #(
   parameter int AW = 32,
   parameter int CW = 32
)(
   input logic           clk,
   input logic           rst_n,
   input logic           go_i,
   input logic [1:0]     ctr_test_i,
   input logic [1:0]     bit_test_i,
   input logic [1:0]     tgt_sel_i,
   input logic           link_i,
   input logic           dec_i,
   input logic [CW-1:0]  mask_i,
   input logic [AW-1:0]  ctr_i,
   input logic [AW-1:0]  lr_i,
   input logic [AW-1:0]  seq_i,
   input logic           redir_o,
   input logic           taken_o,
   input logic [AW-1:0]  next_pc_o,
   input logic           lr_we_o,
   input logic [AW-1:0]  lr_wdata_o,
   input logic           ctr_we_o,
   input logic [AW-1:0]  ctr_wdata_o
);
   p_redir_follows_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
      go_i |=> redir_o);

   p_ctr_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (go_i && !dec_i && ctr_test_i == 2'd1 && bit_test_i == 2'd0 && ctr_i == '0)
      |=> (redir_o && !taken_o));

   p_mask_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (go_i && (bit_test_i == 2'd1 || bit_test_i == 2'd2)) |-> $countones(mask_i) == 1);

   p_ctr_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (go_i && tgt_sel_i == 2'd1 && ctr_test_i == 2'd0 && bit_test_i == 2'd0)
      |=> (taken_o && next_pc_o == {$past(ctr_i[AW-1:2]), 2'b00}));

   p_seq_when_not_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (redir_o && !taken_o) |-> next_pc_o == $past(seq_i));

   p_link_needs_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lr_we_o |-> (redir_o && taken_o && lr_wdata_o == $past(seq_i)));

   p_old_link_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (go_i && link_i && tgt_sel_i == 2'd2 && ctr_test_i == 2'd0 && bit_test_i == 2'd0)
      |=> (next_pc_o == {$past(lr_i[AW-1:2]), 2'b00}));

   p_dec_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dec_i |=> (ctr_we_o && ctr_wdata_o == $past(ctr_i) - AW'(1)));

   p_dec_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (go_i && dec_i && ctr_test_i == 2'd2 && bit_test_i == 2'd0 && ctr_i == AW'(1))
      |=> taken_o);

   p_dec_alone_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!go_i) |=> (!redir_o && !lr_we_o && !taken_o));
endmodule

bind branch_resolve branch_resolve_chk #(.AW(AW), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .go_i(go_i), .ctr_test_i(ctr_test_i),
   .bit_test_i(bit_test_i), .tgt_sel_i(tgt_sel_i), .link_i(link_i),
   .dec_i(dec_i), .mask_i(mask_i), .ctr_i(ctr_i), .lr_i(lr_i), .seq_i(seq_i),
   .redir_o(redir_o), .taken_o(taken_o), .next_pc_o(next_pc_o),
   .lr_we_o(lr_we_o), .lr_wdata_o(lr_wdata_o), .ctr_we_o(ctr_we_o),
   .ctr_wdata_o(ctr_wdata_o)
);

// File: tb/tb_branch_resolve.sv
`timescale 1ns/100ps
module tb_branch_resolve;
   localparam int AW = 32;
   localparam int CW = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           go_i = 1'b0;
   logic [1:0]     ctr_test_i = '0, bit_test_i = '0, tgt_sel_i = '0;
   logic           link_i = 1'b0, dec_i = 1'b0;
   logic [CW-1:0]  cr_i = '0, mask_i = '0;
   logic [AW-1:0]  ctr_i = '0, lr_i = '0, imm_i = '0, seq_i = '0;
   logic           redir_o, taken_o, lr_we_o, ctr_we_o;
   logic [AW-1:0]  next_pc_o, lr_wdata_o, ctr_wdata_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   branch_resolve #(.AW(AW), .CW(CW)) dut (
      .clk(clk), .rst_n(rst_n), .go_i(go_i), .ctr_test_i(ctr_test_i),
      .bit_test_i(bit_test_i), .tgt_sel_i(tgt_sel_i), .link_i(link_i),
      .dec_i(dec_i), .cr_i(cr_i), .mask_i(mask_i), .ctr_i(ctr_i), .lr_i(lr_i),
      .imm_i(imm_i), .seq_i(seq_i), .redir_o(redir_o), .taken_o(taken_o),
      .next_pc_o(next_pc_o), .lr_we_o(lr_we_o), .lr_wdata_o(lr_wdata_o),
      .ctr_we_o(ctr_we_o), .ctr_wdata_o(ctr_wdata_o)
   );

   task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive one operation after a clock edge, then wait for its result cycle.
   task automatic issue(input logic go, input logic [1:0] ct, input logic [1:0] bt,
                        input logic [1:0] ts, input logic lk, input logic dc,
                        input logic [CW-1:0] cr, input logic [CW-1:0] mk,
                        input logic [AW-1:0] ctr, input logic [AW-1:0] lr,
                        input logic [AW-1:0] imm, input logic [AW-1:0] seq);
      go_i = go; ctr_test_i = ct; bit_test_i = bt; tgt_sel_i = ts;
      link_i = lk; dec_i = dc; cr_i = cr; mask_i = mk;
      ctr_i = ctr; lr_i = lr; imm_i = imm; seq_i = seq;
      @(posedge clk); #1;
      go_i = 1'b0; dec_i = 1'b0; link_i = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 redir", AW'(redir_o), 0);
      chk("R1 taken", AW'(taken_o), 0);
      chk("R1 lr_we", AW'(lr_we_o), 0);
      chk("R1 ctr_we", AW'(ctr_we_o), 0);
   endtask

   task automatic t_uncond;
      issue(1, 0, 0, 0, 1, 0, 0, 0, 7, 0, 32'h4000_0010, 32'h0000_0104);
      chk("R2 redir", AW'(redir_o), 1);
      chk("R5 imm target", next_pc_o, 32'h4000_0010);
      chk("R7 lr_we uncond", AW'(lr_we_o), 1);
      chk("R7 lr_wdata", lr_wdata_o, 32'h0000_0104);
      issue(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R2 redir single cycle", AW'(redir_o), 0);
   endtask

   task automatic t_ctr_tests;
      issue(1, 1, 0, 0, 0, 0, 0, 0, 5, 0, 32'h100, 32'h200);
      chk("R3 nonzero taken", AW'(taken_o), 1);
      issue(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 32'h100, 32'h204);
      chk("R3 nonzero at zero", AW'(taken_o), 0);
      chk("R6 seq", next_pc_o, 32'h204);
      issue(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 32'h100, 32'h208);
      chk("R3 zero taken", next_pc_o, 32'h100);
      issue(1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 32'h110, 32'h20c);
      chk("R3 reserved code untested", AW'(taken_o), 1);
   endtask

   task automatic t_bit_tests;
      issue(1, 0, 1, 0, 0, 0, 32'h0000_0100, 32'h0000_0100, 0, 0, 32'h300, 32'h400);
      chk("R4 bit set taken", AW'(taken_o), 1);
      issue(1, 0, 2, 0, 0, 0, 32'h0000_0100, 32'h0000_0100, 0, 0, 32'h300, 32'h404);
      chk("R4 bit clear not taken", next_pc_o, 32'h404);
      issue(1, 0, 2, 0, 0, 0, 32'hFFFF_FEFF, 32'h0000_0100, 0, 0, 32'h300, 32'h408);
      chk("R4 bit clear taken", next_pc_o, 32'h300);
      issue(1, 1, 1, 0, 0, 0, 32'h8000_0000, 32'h8000_0000, 0, 0, 32'h300, 32'h40c);
      chk("R4 set but ctr zero", AW'(taken_o), 0);
      issue(1, 2, 2, 0, 0, 0, 32'h0, 32'h0000_0001, 0, 0, 32'h304, 32'h410);
      chk("R4 zero and clear", next_pc_o, 32'h304);
      issue(1, 2, 1, 0, 0, 0, 32'h0000_0001, 32'h0000_0001, 3, 0, 32'h308, 32'h414);
      chk("R4 zero and set with ctr nonzero", next_pc_o, 32'h414);
   endtask

   task automatic t_targets;
      issue(1, 0, 0, 1, 0, 0, 0, 0, 32'h0000_1003, 32'h0, 32'h500, 32'h600);
      chk("R5 ctr target aligned", next_pc_o, 32'h0000_1000);
      issue(1, 0, 0, 2, 0, 0, 0, 0, 0, 32'h0000_2002, 32'h500, 32'h604);
      chk("R5 lr target aligned", next_pc_o, 32'h0000_2000);
      issue(1, 0, 0, 3, 0, 0, 0, 0, 32'h0000_1003, 32'h2002, 32'h508, 32'h608);
      chk("R5 reserved select uses imm", next_pc_o, 32'h508);
   endtask

   task automatic t_link;
      issue(1, 1, 0, 0, 1, 0, 0, 0, 0, 0, 32'h700, 32'h800);
      chk("R7 no link when not taken", AW'(lr_we_o), 0);
      issue(1, 0, 0, 2, 1, 0, 0, 0, 0, 32'h0000_3007, 32'h700, 32'h804);
      chk("R8 old link target", next_pc_o, 32'h0000_3004);
      chk("R8 new link value", lr_wdata_o, 32'h804);
      chk("R8 link written", AW'(lr_we_o), 1);
   endtask

   task automatic t_dec;
      issue(0, 0, 0, 0, 1, 1, 0, 0, 32'h0000_0009, 0, 32'h900, 32'hA00);
      chk("R9 ctr_we", AW'(ctr_we_o), 1);
      chk("R9 ctr value", ctr_wdata_o, 32'h0000_0008);
      chk("R11 no redirect", AW'(redir_o), 0);
      chk("R11 no link write", AW'(lr_we_o), 0);
      issue(0, 0, 0, 0, 0, 1, 0, 0, 32'h0, 0, 0, 0);
      chk("R9 wrap", ctr_wdata_o, 32'hFFFF_FFFF);
      issue(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R9 ctr_we drops", AW'(ctr_we_o), 0);
   endtask

   task automatic t_dec_branch;
      issue(1, 1, 0, 0, 0, 1, 0, 0, 32'h1, 0, 32'hB00, 32'hC00);
      chk("R10 nonzero sees decremented", AW'(taken_o), 0);
      issue(1, 2, 0, 0, 0, 1, 0, 0, 32'h1, 0, 32'hB00, 32'hC04);
      chk("R10 zero sees decremented", next_pc_o, 32'hB00);
      issue(1, 1, 1, 1, 0, 1, 32'h10, 32'h10, 32'h0000_0046, 0, 32'hB00, 32'hC08);
      chk("R10 ctr target undecremented", next_pc_o, 32'h0000_0044);
      chk("R10 ctr write", ctr_wdata_o, 32'h0000_0045);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_uncond();
      t_ctr_tests();
      t_bit_tests();
      t_targets();
      t_link();
      t_dec();
      t_dec_branch();
      finish_run();
   end
endmodule